// File: doc/BRIEF.md
# UART Configuration Register Bank with Shared-Address Steering

This block holds the configuration state of a serial port: an 8-bit low baud-divisor byte, a narrow high baud-divisor field, and a frame-control register that carries the character-size code. Software reaches these registers over a byte-wide bus with a write strobe, an address and write data. Reads are combinational from the address.

Address space can be tight. The build may therefore place the high-divisor register and the frame-control register at one bus address. In that layout, bit 7 of each write to the shared address picks the target: bit 7 clear loads the high-divisor field, and bit 7 set loads the frame-control register. A control write can therefore never disturb the baud rate. When a parameter gives the high-divisor register its own address, writes to it load the field whatever bit 7 holds.

The bank drives three outputs for the rest of the serial port, all taken from its stored registers: the 12-bit divisor, the decoded character length, and a one-cycle pulse each time a divisor register takes a new value.

Top module: `uart_cfg_regs`

## Requirements
- R1: While rst_ni is low, and afterwards until the first write, the divisor is 0, the character length is 8, the change pulse is low, and a read of the frame-control address returns 8'h86.
- R2: In the shared layout, a write to the shared address with bit 7 = 0 loads the high-divisor field. It leaves the frame-control register unchanged.
- R3: In the shared layout, a write to the shared address with bit 7 = 1 loads bits 6:0 of the frame-control register. The divisor stays unchanged and no change pulse occurs.
- R4: In the separate layout, a write to the high-divisor address loads the field whatever bit 7 holds. A write to the frame-control address loads bits 6:0 whatever bit 7 holds.
- R5: baud_div_o equals the low byte ORed with the high field shifted left by 8.
- R6: A high-divisor write stores only write-data bits 3:0. In the separate layout, a read of the high-divisor address returns the field in bits 3:0 and zeros in bits 7:4.
- R7: The size code is {ctrl[3], ctrl[2:1]}. Codes 0 to 3 give lengths 5 to 8. Codes 4, 5 and 6 give 8. Code 7 gives 9.
- R8: A read of the low address returns the low byte. A read of the frame-control address returns bit 7 set above stored bits 6:0. An unmapped address reads 0.
- R9: div_chg_o is high for the one cycle after a write that changes a divisor value. It stays low when a write leaves the value the same.
- R10: A register changes only at a clock edge where we_i is high and the address maps to it. Writes to unmapped addresses, and cycles with we_i low, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| baud_div_o | output | 12 | Combined baud divisor |
| char_len_o | output | 4 | Decoded data bits per character |
| div_chg_o | output | 1 | One-cycle pulse after a divisor change |

## Verification
If the steering state were wrong, a control write at the shared address would move baud_div_o on the very next edge. The same fault would show as a frame-control readback that changes after a divisor write. Every register feeds an output or a read path combinationally, so a wrong stored bit becomes visible one clock after the write that caused it. The change pulse shows any mismatch in how a stored value is compared, because it fires or stays silent in that same cycle.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTRL_W = 7;
  localparam int unsigned LEN_W  = 4;
  localparam int unsigned SZ_LSB = 1;  // two low size bits at ctrl[2:1]
  localparam int unsigned SZ_MSB = 3;  // third size bit at ctrl[3]
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'b000_0110;

  typedef logic [2:0] size_code_t;

  function automatic logic [LEN_W-1:0] len_of(size_code_t c);
    case (c)
      3'd0:    len_of = 4'd5;
      3'd1:    len_of = 4'd6;
      3'd2:    len_of = 4'd7;
      3'd7:    len_of = 4'd9;
      default: len_of = 4'd8;  // 3 and the reserved codes
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int unsigned ADDR_W    = 2,
  parameter bit          SHARED_HI = 1'b1,
  parameter int unsigned ADDR_LO   = 0,
  parameter int unsigned ADDR_HI   = 1,
  parameter int unsigned ADDR_CTRL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              steer_i,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              wr_ctrl_o
);
  logic hit_lo, hit_hi, hit_ctrl;

  assign hit_lo   = (addr_i == ADDR_W'(ADDR_LO));
  assign hit_hi   = (addr_i == ADDR_W'(ADDR_HI));
  assign hit_ctrl = (addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_lo_o  = we_i && hit_lo;

  generate
    if (SHARED_HI) begin : g_shared
      assign wr_hi_o   = we_i && hit_hi && !steer_i;
      assign wr_ctrl_o = we_i && hit_ctrl && steer_i;
    end else begin : g_split
      assign wr_hi_o   = we_i && hit_hi;
      assign wr_ctrl_o = we_i && hit_ctrl;
    end
  endgenerate

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_lo_o, wr_hi_o, wr_ctrl_o}));  // R2
  AST_NO_WE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |-> !(wr_lo_o || wr_hi_o || wr_ctrl_o));  // R10
endmodule

// File: rtl/cfg_div_regs.sv
module cfg_div_regs #(
  parameter int unsigned HI_W   = 4,
  parameter int unsigned HI_LSB = 0
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_lo_i,
  input  logic                              wr_hi_i,
  input  logic [uart_cfg_pkg::BYTE_W-1:0]   wdata_i,
  output logic [uart_cfg_pkg::BYTE_W-1:0]   lo_o,
  output logic [HI_W-1:0]                   hi_o,
  output logic                              chg_o
);
  import uart_cfg_pkg::*;

  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q, hi_field;
  logic              chg_q, lo_diff, hi_diff;

  assign hi_field = wdata_i[HI_LSB +: HI_W];  // field mask after the shift
  assign lo_diff  = wr_lo_i && (wdata_i != lo_q);
  assign hi_diff  = wr_hi_i && (hi_field != hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      hi_q  <= '0;
      chg_q <= 1'b0;
    end else begin
      if (wr_lo_i) lo_q <= wdata_i;
      if (wr_hi_i) hi_q <= hi_field;
      chg_q <= lo_diff || hi_diff;
    end
  end

  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign chg_o = chg_q;

  AST_HI_LOADS_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> hi_q == $past(wdata_i[HI_LSB +: HI_W]));  // R6
  AST_CHG_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> $past(wr_lo_i || wr_hi_i));  // R9
  AST_HI_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(hi_q));  // R10
endmodule

// File: rtl/cfg_frame_reg.sv
module cfg_frame_reg (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [uart_cfg_pkg::BYTE_W-1:0]   wdata_i,
  output logic [uart_cfg_pkg::CTRL_W-1:0]   ctrl_o,
  output logic [uart_cfg_pkg::LEN_W-1:0]    len_o
);
  import uart_cfg_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  size_code_t        code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (wr_i) ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  assign code   = {ctrl_q[SZ_MSB], ctrl_q[SZ_LSB +: 2]};
  assign len_o  = len_of(code);
  assign ctrl_o = ctrl_q;

  AST_LEN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_o >= 4'd5) && (len_o <= 4'd9));  // R7
  AST_CTRL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_q));  // R10
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs #(
  parameter int unsigned ADDR_W      = 2,
  parameter bit          SHARED_HI   = 1'b1,
  parameter int unsigned ADDR_LO     = 0,
  parameter int unsigned ADDR_CTRL   = 1,
  parameter int unsigned ADDR_HI_SEP = 3,
  parameter int unsigned HI_W        = 4,
  parameter int unsigned HI_LSB      = 0,
  localparam int unsigned DIV_W      = uart_cfg_pkg::BYTE_W + HI_W
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [uart_cfg_pkg::BYTE_W-1:0] wdata_i,
  output logic [uart_cfg_pkg::BYTE_W-1:0] rdata_o,
  output logic [DIV_W-1:0]                baud_div_o,
  output logic [uart_cfg_pkg::LEN_W-1:0]  char_len_o,
  output logic                            div_chg_o
);
  import uart_cfg_pkg::*;

  localparam int unsigned ADDR_HI = SHARED_HI ? ADDR_CTRL : ADDR_HI_SEP;

  logic              wr_lo, wr_hi, wr_ctrl;
  logic [BYTE_W-1:0] lo;
  logic [HI_W-1:0]   hi;
  logic [CTRL_W-1:0] ctrl;

  cfg_addr_dec #(
    .ADDR_W(ADDR_W), .SHARED_HI(SHARED_HI),
    .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .ADDR_CTRL(ADDR_CTRL)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .steer_i(wdata_i[BYTE_W-1]),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .wr_ctrl_o(wr_ctrl)
  );

  cfg_div_regs #(.HI_W(HI_W), .HI_LSB(HI_LSB)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(wdata_i), .lo_o(lo), .hi_o(hi), .chg_o(div_chg_o)
  );

  cfg_frame_reg u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ctrl), .wdata_i(wdata_i),
    .ctrl_o(ctrl), .len_o(char_len_o)
  );

  assign baud_div_o = DIV_W'(lo) | (DIV_W'(hi) << BYTE_W);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_LO))   rdata_o = lo;
    if (addr_i == ADDR_W'(ADDR_CTRL)) rdata_o = {1'b1, ctrl};
    if (!SHARED_HI && addr_i == ADDR_W'(ADDR_HI))
      rdata_o = {{(BYTE_W-HI_W){1'b0}}, hi};
  end

  AST_CTRL_WR_KEEPS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SHARED_HI && we_i && addr_i == ADDR_W'(ADDR_CTRL) && wdata_i[BYTE_W-1])
      |=> ($stable(baud_div_o) && !div_chg_o));  // R3
  AST_HI_WR_KEEPS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SHARED_HI && we_i && addr_i == ADDR_W'(ADDR_CTRL) && !wdata_i[BYTE_W-1])
      |=> $stable(char_len_o));  // R2
  AST_IDLE_KEEPS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(baud_div_o) && !div_chg_o));  // R10
endmodule

// File: tb/tb_uart_cfg_regs.sv
module tb_uart_cfg_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       s_we = 0, p_we = 0;
  logic [1:0] s_addr = 0, p_addr = 0;
  logic [7:0] s_wd = 0, p_wd = 0, s_rd, p_rd;
  logic [11:0] s_div, p_div;
  logic [3:0]  s_len, p_len;
  logic        s_chg, p_chg;

  int errors = 0, checks = 0;
  bit done = 0;

  uart_cfg_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(s_we), .addr_i(s_addr), .wdata_i(s_wd),
    .rdata_o(s_rd), .baud_div_o(s_div), .char_len_o(s_len), .div_chg_o(s_chg));

  uart_cfg_regs #(.SHARED_HI(1'b0)) dut_sep (
    .clk_i(clk), .rst_ni(rst_n), .we_i(p_we), .addr_i(p_addr), .wdata_i(p_wd),
    .rdata_o(p_rd), .baud_div_o(p_div), .char_len_o(p_len), .div_chg_o(p_chg));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write, then leave the bench at the negedge after the capturing edge
  task automatic wr_s(logic [1:0] a, logic [7:0] d);
    @(negedge clk); s_we = 1; s_addr = a; s_wd = d;
    @(negedge clk); s_we = 0; #1;
  endtask
  task automatic wr_p(logic [1:0] a, logic [7:0] d);
    @(negedge clk); p_we = 1; p_addr = a; p_wd = d;
    @(negedge clk); p_we = 0; #1;
  endtask
  task automatic rd_s(logic [1:0] a, output logic [7:0] d);
    s_addr = a; #1; d = s_rd;
  endtask
  task automatic rd_p(logic [1:0] a, output logic [7:0] d);
    p_addr = a; #1; d = p_rd;
  endtask

  function automatic int exp_len(int c);
    if (c < 4) return 5 + c;
    if (c == 7) return 9;
    return 8;
  endfunction

  function automatic logic [7:0] ctrl_byte(int c, bit b7);
    return {b7, 3'b000, 1'(c >> 2), 2'(c), 1'b0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int lo_e, hi_e;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state, during reset
    check("R1 div", s_div, 0);
    check("R1 len", s_len, 8);
    check("R1 chg", s_chg, 0);
    rst_n = 1;
    @(negedge clk); #1;
    rd_s(2'd1, r); check("R1 ctrl read", r, 8'h86);
    check("R1 sep div", p_div, 0);
    check("R1 sep len", p_len, 8);

    // R5/R9 sweep over high field and low byte values on the shared layout
    lo_e = 0; hi_e = 0;
    for (int h = 0; h < 16; h++) begin
      wr_s(2'd1, 8'(h));  // bit 7 clear: high field (R2)
      check("R9 hi chg", s_chg, (h != hi_e) ? 1 : 0);
      hi_e = h;
      for (int k = 0; k < 6; k++) begin
        wr_s(2'd0, 8'(k * 8'h33));
        check("R9 lo chg", s_chg, ((k * 8'h33) != lo_e) ? 1 : 0);
        lo_e = k * 8'h33;
        check("R5 div", s_div, (hi_e << 8) | lo_e);
      end
      @(negedge clk); #1;
      check("R9 pulse ends", s_chg, 0);
    end
    rd_s(2'd1, r); check("R2 ctrl unchanged", r, 8'h86);
    rd_s(2'd0, r); check("R8 lo read", r, lo_e);

    // R9 same-value rewrite gives no pulse
    wr_s(2'd0, 8'(lo_e));
    check("R9 same lo", s_chg, 0);
    wr_s(2'd1, 8'(hi_e));
    check("R9 same hi", s_chg, 0);

    // R6 only bits 3:0 stored
    wr_s(2'd0, 8'h12);
    wr_s(2'd1, 8'h7A);
    check("R6 masked hi", s_div, 12'hA12);

    // R3 control write at shared address with bit 7 set
    wr_s(2'd1, 8'h8E);
    check("R3 div kept", s_div, 12'hA12);
    check("R3 no chg", s_chg, 0);
    check("R3 len", s_len, 9);
    rd_s(2'd1, r); check("R3 ctrl read", r, 8'h8E);
    // R2 divisor write leaves control alone
    wr_s(2'd1, 8'h05);
    check("R2 div", s_div, 12'h512);
    check("R2 len", s_len, 9);
    rd_s(2'd1, r); check("R2 ctrl read", r, 8'h8E);

    // R7 all size codes through the shared layout
    for (int c = 0; c < 8; c++) begin
      wr_s(2'd1, ctrl_byte(c, 1'b1));
      check("R7 len", s_len, exp_len(c));
      check("R3 div kept in sweep", s_div, 12'h512);
    end

    // R10 no write when we_i low; unmapped address writes ignored
    @(negedge clk); s_addr = 2'd1; s_wd = 8'h03; @(negedge clk); #1;
    check("R10 idle div", s_div, 12'h512);
    wr_s(2'd3, 8'h0F);
    wr_s(2'd2, 8'h8F);
    check("R10 unmapped div", s_div, 12'h512);
    check("R10 unmapped len", s_len, exp_len(7));
    rd_s(2'd2, r); check("R8 unmapped read", r, 0);
    rd_s(2'd3, r); check("R8 unmapped read 3", r, 0);

    // R4/R6 separate layout
    wr_p(2'd3, 8'hA9);
    check("R4 sep hi", p_div, 12'h900);
    check("R9 sep chg", p_chg, 1);
    rd_p(2'd3, r); check("R6 sep hi read", r, 8'h09);
    wr_p(2'd3, 8'h8C);
    check("R4 sep hi bit7", p_div, 12'hC00);
    rd_p(2'd1, r); check("R4 sep ctrl kept", r, 8'h86);
    wr_p(2'd0, 8'h3C);
    check("R5 sep div", p_div, 12'hC3C);
    for (int c = 0; c < 8; c++) begin
      wr_p(2'd1, ctrl_byte(c, c[0]));
      check("R4 sep len", p_len, exp_len(c));
      check("R4 sep div kept", p_div, 12'hC3C);
      rd_p(2'd1, r); check("R8 sep ctrl read", r, {1'b1, ctrl_byte(c, 1'b0)[6:0]});
    end

    // R1 reset again clears everything
    @(negedge clk); rst_n = 0; #1;
    check("R1 rst div", s_div, 0);
    check("R1 rst len", s_len, 8);
    check("R1 rst sep div", p_div, 0);
    @(negedge clk); rst_n = 1;
    finish_run();
  end
endmodule